// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps routing and delivery state for a fixed set of interrupt sources. Sources are numbered upward from a base number `SRC_BASE`. The entry index is the source number minus the base. Each entry holds the following:

- a destination server index
- an 8-bit priority and an 8-bit saved priority; priority 0xFF means the source is masked
- a type, level or message, fixed per entry by the `LEVEL_MASK` parameter (bit i set means entry i is level-type)
- four flags: asserted, sent, rejected and masked-pending

The block takes three kinds of input. Interrupt events arrive from the sources. Routing commands arrive from a control agent. Reject, end-of-interrupt (EOI) and resend pulses arrive from the presentation stage that sits downstream. From these the block produces single-cycle offers, each carrying a source number, a server and a priority. The presentation stage either takes an offer or refuses it. A refused offer is recorded through a reject pulse and replayed later by a resend scan. The scan walks every entry in order, one per cycle.

Top module: `irq_src_ctl`

## Requirements
- R1: A source number is accepted only if it lies in [SRC_BASE, SRC_BASE+NUM_SRC). Events, rejects and EOIs outside that range change nothing. A command outside that range completes with `cfg_err`=1.
- R2: After reset no offer is made. Every flag is clear, every server is 0, and every priority and saved priority is 0xFF.
- R3: A message-type source with priority other than 0xFF that receives an event with `evt_level`=1 is offered in the next cycle with its own number, server and priority. An event with `evt_level`=0 on a message source does nothing.
- R4: A message event that arrives while the priority is 0xFF makes no offer and sets masked-pending. A later command that leaves a priority other than 0xFF clears masked-pending and offers the source once.
- R5: On a level-type source, an event copies `evt_level` into the asserted flag and then tries a level resend. The level resend offers the source and sets sent only when the priority is not 0xFF, asserted is set and sent is clear.
- R6: A reject sets the rejected flag and clears the sent flag of its entry, for either type. It makes no offer.
- R7: An EOI clears sent on a level-type entry only. It makes no offer.
- R8: A resend pulse starts a scan from entry 0 that handles one entry per cycle. A level entry gets a level resend. A message entry with rejected set has rejected cleared and is offered again if its priority is not 0xFF. The scan does not advance in any cycle where an event, command, reject or EOI is present.
- R9: SET (`cfg_cmd`=0) fails with `cfg_err`=1 and changes nothing if `cfg_server` is not below NUM_SRV. Otherwise it writes the server, and it writes `cfg_prio` into both the priority and the saved priority.
- R10: OFF (`cfg_cmd`=1) copies the current priority into the saved priority and sets the priority to 0xFF. ON (`cfg_cmd`=2) copies the saved priority back into the priority. After SET, OFF or ON, a message entry applies the rule of R4 and a level entry tries a level resend.
- R11: READ (`cfg_cmd`=3) changes nothing and makes no offer. It returns the server on `cfg_rd_server` and the priority on `cfg_rd_prio`.
- R12: When more than one request arrives in a cycle, only one is acted on, in this order: reject, then EOI, then event, then command. Lower-ranked requests are dropped, and a dropped command raises no `cfg_done`.
- R13: An accepted command raises `cfg_done` one cycle later. At the same time `cfg_err` is 0 for success or 1 for refusal. On success the read fields show the entry's server and priority after the command. On refusal they show 0.

Note the OFF corner in R10: OFF issued twice in a row saves 0xFF over the earlier priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Interrupt event strobe |
| evt_src | input | SRC_W | Source number of the event |
| evt_level | input | 1 | Event level (1 = raise) |
| cfg_valid | input | 1 | Routing command strobe |
| cfg_cmd | input | 2 | 0 SET, 1 OFF, 2 ON, 3 READ |
| cfg_src | input | SRC_W | Source number addressed by the command |
| cfg_server | input | SRV_IN_W | Server index for SET |
| cfg_prio | input | 8 | Priority for SET |
| cfg_done | output | 1 | Command completed |
| cfg_err | output | 1 | Command refused |
| cfg_rd_server | output | SRV_W | Entry server after the command |
| cfg_rd_prio | output | 8 | Entry priority after the command |
| rej_valid | input | 1 | Reject pulse |
| rej_src | input | SRC_W | Rejected source number |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_src | input | SRC_W | Source number being completed |
| resend | input | 1 | Start a resend scan |
| offer_valid | output | 1 | Offer strobe |
| offer_src | output | SRC_W | Offered source number |
| offer_server | output | SRV_W | Destination server |
| offer_prio | output | 8 | Offered priority |

## Verification
The bench targets these corner cases:

- **Masked message event.** A message event that arrives while masked must be remembered. A design that drops it never delivers the event after unmasking. A design that keeps masked-pending set delivers it twice.
- **Level re-offer.** A level source that stays asserted must not be offered again until an EOI or a reject clears sent. Getting this wrong produces repeated offers, or the source is lost after ON restores its priority.
- **Resend scan.** The scan must replay only rejected message entries and unsent level entries, in entry order. It must also hold still behind foreground traffic. A scan that ignores the stall would emit an offer during a READ.
- **Command checks.** A wrong range test or server check shows up as a missing or false error on an out-of-range source or server.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  localparam logic [7:0] PRIO_MASKED = 8'hFF;

  typedef enum logic [1:0] {
    CMD_SET  = 2'd0,
    CMD_OFF  = 2'd1,
    CMD_ON   = 2'd2,
    CMD_READ = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_REJ  = 3'd1,
    SEL_EOI  = 3'd2,
    SEL_EVT  = 3'd3,
    SEL_CFG  = 3'd4,
    SEL_SCAN = 3'd5
  } sel_e;

  typedef struct packed {
    logic [7:0] prio;
    logic [7:0] saved;
    logic       asserted;
    logic       sent;
    logic       rejected;
    logic       mpend;
  } src_state_t;

  localparam src_state_t RST_STATE = '{prio: PRIO_MASKED, saved: PRIO_MASKED,
                                       asserted: 1'b0, sent: 1'b0,
                                       rejected: 1'b0, mpend: 1'b0};

  // level delivery condition: unmasked, line high, not yet delivered
  function automatic logic lvl_ready(src_state_t s);
    return (s.prio != PRIO_MASKED) && s.asserted && !s.sent;
  endfunction

endpackage

// File: rtl/irq_src_range.sv
module irq_src_range #(
  parameter int SRC_W    = 10,
  parameter int NUM_SRC  = 8,
  parameter int SRC_BASE = 16,
  parameter int IDX_W    = 3
) (
  input  logic [SRC_W-1:0] src,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic [SRC_W-1:0] rel;

  assign rel = src - SRC_W'(SRC_BASE);
  assign hit = (src >= SRC_W'(SRC_BASE)) && (rel < SRC_W'(NUM_SRC));
  assign idx = rel[IDX_W-1:0];
endmodule

// File: rtl/irq_src_scan.sv
module irq_src_scan #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stall,
  output logic             step,
  output logic [IDX_W-1:0] idx
);
  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    step   = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q && !stall) begin
      step = 1'b1;
      if (idx_q == IDX_W'(NUM_SRC - 1)) begin
        busy_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  assign idx = idx_q;
endmodule

// File: rtl/irq_src_table.sv
module irq_src_table
  import irq_src_pkg::*;
#(
  parameter int                SRC_W      = 10,
  parameter int                NUM_SRC    = 8,
  parameter int                SRC_BASE   = 16,
  parameter int                NUM_SRV    = 4,
  parameter int                SRV_IN_W   = 8,
  parameter int                SRV_W      = 2,
  parameter int                IDX_W      = 3,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_v,
  input  logic                evt_hit,
  input  logic [IDX_W-1:0]    evt_idx,
  input  logic                evt_lvl,
  input  logic                cfg_v,
  input  logic                cfg_hit,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [1:0]          cfg_cmd,
  input  logic [SRV_IN_W-1:0] cfg_server,
  input  logic [7:0]          cfg_prio,
  input  logic                rej_v,
  input  logic                rej_hit,
  input  logic [IDX_W-1:0]    rej_idx,
  input  logic                eoi_v,
  input  logic                eoi_hit,
  input  logic [IDX_W-1:0]    eoi_idx,
  input  logic                scan_step,
  input  logic [IDX_W-1:0]    scan_idx,
  output logic                offer_valid,
  output logic [SRC_W-1:0]    offer_src,
  output logic [SRV_W-1:0]    offer_server,
  output logic [7:0]          offer_prio,
  output logic                cfg_done,
  output logic                cfg_err,
  output logic [SRV_W-1:0]    rd_server,
  output logic [7:0]          rd_prio
);
  src_state_t       st_q  [NUM_SRC];
  logic [SRV_W-1:0] srv_q [NUM_SRC];

  sel_e             sel;
  logic [IDX_W-1:0] sel_idx;
  logic             act;
  src_state_t       cur_st, nxt_st;
  logic [SRV_W-1:0] cur_srv, nxt_srv;
  logic             is_lvl, wr, post_wr;
  logic             off_d, done_d, err_d;

  // arbitration: reject > eoi > event > command > scan step
  always_comb begin
    sel     = SEL_NONE;
    sel_idx = '0;
    act     = 1'b0;
    if (rej_v) begin
      sel = SEL_REJ;  sel_idx = rej_idx;  act = rej_hit;
    end else if (eoi_v) begin
      sel = SEL_EOI;  sel_idx = eoi_idx;  act = eoi_hit;
    end else if (evt_v) begin
      sel = SEL_EVT;  sel_idx = evt_idx;  act = evt_hit;
    end else if (cfg_v) begin
      sel = SEL_CFG;  sel_idx = cfg_idx;  act = cfg_hit;
    end else if (scan_step) begin
      sel = SEL_SCAN; sel_idx = scan_idx; act = 1'b1;
    end
  end

  assign cur_st  = st_q[sel_idx];
  assign cur_srv = srv_q[sel_idx];
  assign is_lvl  = LEVEL_MASK[sel_idx];

  always_comb begin
    nxt_st  = cur_st;
    nxt_srv = cur_srv;
    wr      = 1'b0;
    post_wr = 1'b0;
    off_d   = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (sel)
      SEL_REJ: if (act) begin
        wr              = 1'b1;
        nxt_st.rejected = 1'b1;
        nxt_st.sent     = 1'b0;
      end
      SEL_EOI: if (act && is_lvl) begin
        wr          = 1'b1;
        nxt_st.sent = 1'b0;
      end
      SEL_EVT: if (act) begin
        wr = 1'b1;
        if (is_lvl) begin
          nxt_st.asserted = evt_lvl;
          if (lvl_ready(nxt_st)) begin
            nxt_st.sent = 1'b1;
            off_d       = 1'b1;
          end
        end else if (evt_lvl) begin
          if (cur_st.prio == PRIO_MASKED) nxt_st.mpend = 1'b1;
          else                            off_d        = 1'b1;
        end
      end
      SEL_CFG: begin
        done_d = 1'b1;
        if (!act) begin
          err_d = 1'b1;
        end else begin
          unique case (cmd_e'(cfg_cmd))
            CMD_SET: begin
              if (cfg_server >= SRV_IN_W'(NUM_SRV)) begin
                err_d = 1'b1;
              end else begin
                nxt_srv      = cfg_server[SRV_W-1:0];
                nxt_st.prio  = cfg_prio;
                nxt_st.saved = cfg_prio;
                post_wr      = 1'b1;
              end
            end
            CMD_OFF: begin
              nxt_st.saved = cur_st.prio;
              nxt_st.prio  = PRIO_MASKED;
              post_wr      = 1'b1;
            end
            CMD_ON: begin
              nxt_st.prio = cur_st.saved;
              post_wr     = 1'b1;
            end
            default: ;
          endcase
          if (post_wr) begin
            wr = 1'b1;
            if (is_lvl) begin
              if (lvl_ready(nxt_st)) begin
                nxt_st.sent = 1'b1;
                off_d       = 1'b1;
              end
            end else if (nxt_st.mpend && (nxt_st.prio != PRIO_MASKED)) begin
              nxt_st.mpend = 1'b0;
              off_d        = 1'b1;
            end
          end
        end
      end
      SEL_SCAN: begin
        wr = 1'b1;
        if (is_lvl) begin
          if (lvl_ready(cur_st)) begin
            nxt_st.sent = 1'b1;
            off_d       = 1'b1;
          end
        end else if (cur_st.rejected) begin
          nxt_st.rejected = 1'b0;
          off_d           = (cur_st.prio != PRIO_MASKED);
        end
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ent
    src_state_t       st_r;
    logic [SRV_W-1:0] srv_r;
    logic             en;

    assign en = wr && (sel_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= RST_STATE;
        srv_r <= '0;
      end else if (en) begin
        st_r  <= nxt_st;
        srv_r <= nxt_srv;
      end
    end

    assign st_q[g]  = st_r;
    assign srv_q[g] = srv_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offer_valid  <= 1'b0;
      offer_src    <= '0;
      offer_server <= '0;
      offer_prio   <= '0;
      cfg_done     <= 1'b0;
      cfg_err      <= 1'b0;
      rd_server    <= '0;
      rd_prio      <= '0;
    end else begin
      offer_valid <= off_d;
      cfg_done    <= done_d;
      if (off_d) begin
        offer_src    <= SRC_W'(SRC_BASE) + SRC_W'(sel_idx);
        offer_server <= nxt_srv;
        offer_prio   <= nxt_st.prio;
      end
      if (done_d) begin
        cfg_err   <= err_d;
        rd_server <= err_d ? '0 : nxt_srv;
        rd_prio   <= err_d ? '0 : nxt_st.prio;
      end
    end
  end
endmodule

// File: rtl/irq_src_ctl.sv
module irq_src_ctl
  import irq_src_pkg::*;
#(
  parameter int                 SRC_W      = 10,
  parameter int                 NUM_SRC    = 8,
  parameter int                 SRC_BASE   = 16,
  parameter int                 NUM_SRV    = 4,
  parameter int                 SRV_IN_W   = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hF0,
  localparam int                SRV_W      = (NUM_SRV > 1) ? $clog2(NUM_SRV) : 1,
  localparam int                IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_valid,
  input  logic [SRC_W-1:0]    evt_src,
  input  logic                evt_level,
  input  logic                cfg_valid,
  input  logic [1:0]          cfg_cmd,
  input  logic [SRC_W-1:0]    cfg_src,
  input  logic [SRV_IN_W-1:0] cfg_server,
  input  logic [7:0]          cfg_prio,
  output logic                cfg_done,
  output logic                cfg_err,
  output logic [SRV_W-1:0]    cfg_rd_server,
  output logic [7:0]          cfg_rd_prio,
  input  logic                rej_valid,
  input  logic [SRC_W-1:0]    rej_src,
  input  logic                eoi_valid,
  input  logic [SRC_W-1:0]    eoi_src,
  input  logic                resend,
  output logic                offer_valid,
  output logic [SRC_W-1:0]    offer_src,
  output logic [SRV_W-1:0]    offer_server,
  output logic [7:0]          offer_prio
);
  localparam int NPORT = 4;  // 0 reject, 1 eoi, 2 event, 3 command

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [SRC_W-1:0] port_src [NPORT];
  logic             port_hit [NPORT];
  logic [IDX_W-1:0] port_idx [NPORT];
  logic             fg_busy, scan_step;
  logic [IDX_W-1:0] scan_idx;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign port_src[0] = rej_src;
  assign port_src[1] = eoi_src;
  assign port_src[2] = evt_src;
  assign port_src[3] = cfg_src;

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    irq_src_range #(
      .SRC_W(SRC_W), .NUM_SRC(NUM_SRC), .SRC_BASE(SRC_BASE), .IDX_W(IDX_W)
    ) u_range (
      .src(port_src[p]), .hit(port_hit[p]), .idx(port_idx[p])
    );
  end

  assign fg_busy = rej_valid | eoi_valid | evt_valid | cfg_valid;

  irq_src_scan #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst_n(rst_int_n), .start(resend), .stall(fg_busy),
    .step(scan_step), .idx(scan_idx)
  );

  irq_src_table #(
    .SRC_W(SRC_W), .NUM_SRC(NUM_SRC), .SRC_BASE(SRC_BASE), .NUM_SRV(NUM_SRV),
    .SRV_IN_W(SRV_IN_W), .SRV_W(SRV_W), .IDX_W(IDX_W), .LEVEL_MASK(LEVEL_MASK)
  ) u_table (
    .clk(clk), .rst_n(rst_int_n),
    .evt_v(evt_valid), .evt_hit(port_hit[2]), .evt_idx(port_idx[2]), .evt_lvl(evt_level),
    .cfg_v(cfg_valid), .cfg_hit(port_hit[3]), .cfg_idx(port_idx[3]), .cfg_cmd(cfg_cmd),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio),
    .rej_v(rej_valid), .rej_hit(port_hit[0]), .rej_idx(port_idx[0]),
    .eoi_v(eoi_valid), .eoi_hit(port_hit[1]), .eoi_idx(port_idx[1]),
    .scan_step(scan_step), .scan_idx(scan_idx),
    .offer_valid(offer_valid), .offer_src(offer_src),
    .offer_server(offer_server), .offer_prio(offer_prio),
    .cfg_done(cfg_done), .cfg_err(cfg_err),
    .rd_server(cfg_rd_server), .rd_prio(cfg_rd_prio)
  );
endmodule

// File: rtl/irq_src_ctl_chk.sv
module irq_src_ctl_chk #(
  parameter int SRC_W    = 10,
  parameter int NUM_SRC  = 8,
  parameter int SRC_BASE = 16,
  parameter int NUM_SRV  = 4,
  parameter int SRV_IN_W = 8,
  parameter int SRV_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                evt_valid,
  input logic                cfg_valid,
  input logic [1:0]          cfg_cmd,
  input logic [SRV_IN_W-1:0] cfg_server,
  input logic                rej_valid,
  input logic                eoi_valid,
  input logic                offer_valid,
  input logic [SRC_W-1:0]    offer_src,
  input logic [SRV_W-1:0]    offer_server,
  input logic [7:0]          offer_prio,
  input logic                cfg_done,
  input logic                cfg_err
);
  a_r1_offer_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> (offer_src >= SRC_W'(SRC_BASE)) &&
                    (offer_src < SRC_W'(SRC_BASE + NUM_SRC)));

  a_r3_offer_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> (offer_prio != 8'hFF));

  a_r9_server_bound: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> (int'(offer_server) < NUM_SRV));

  a_r9_bad_server_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && $past(cfg_cmd == 2'd0 && cfg_server >= SRV_IN_W'(NUM_SRV))) |-> cfg_err);

  a_r6_rej_eoi_silent: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> !$past(rej_valid || eoi_valid));

  a_r8_read_stalls_scan: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> !$past(cfg_valid && cfg_cmd == 2'd3 && !evt_valid));

  a_r13_done_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> $past(cfg_valid && !evt_valid && !rej_valid && !eoi_valid));
endmodule

bind irq_src_ctl irq_src_ctl_chk #(
  .SRC_W(SRC_W), .NUM_SRC(NUM_SRC), .SRC_BASE(SRC_BASE), .NUM_SRV(NUM_SRV),
  .SRV_IN_W(SRV_IN_W), .SRV_W(SRV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .cfg_valid(cfg_valid),
  .cfg_cmd(cfg_cmd), .cfg_server(cfg_server), .rej_valid(rej_valid),
  .eoi_valid(eoi_valid), .offer_valid(offer_valid), .offer_src(offer_src),
  .offer_server(offer_server), .offer_prio(offer_prio),
  .cfg_done(cfg_done), .cfg_err(cfg_err)
);

// File: tb/sim_irq_src_ctl.sv
module sim_irq_src_ctl;
  localparam int K_EVT = 0, K_CFG = 1, K_REJ = 2, K_EOI = 3;

  typedef struct packed {
    logic [2:0] kind;
    logic [1:0] cmd;
    logic [9:0] src;
    logic [7:0] srv;
    logic [7:0] prio;
    logic       lvl;
    logic       x_off;
    logic [9:0] x_src;
    logic [1:0] x_srv;
    logic [7:0] x_prio;
    logic       x_done;
    logic       x_err;
    logic [1:0] x_rsrv;
    logic [7:0] x_rprio;
    logic [3:0] req;
  } vec_t;

  // sources 16..19 message-type, 20..23 level-type
  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{1, 3, 16, 0, 0, 0, 0,  0, 0, 0, 1, 0, 0, 255,  2}, // R2 R11 read after reset
    '{0, 0, 16, 0, 0, 1, 0,  0, 0, 0, 0, 0, 0,   0,  4}, // R4 masked event
    '{1, 0, 16, 2, 5, 0, 1, 16, 2, 5, 1, 0, 2,   5,  4}, // R4 R9 set releases pending
    '{0, 0, 16, 0, 0, 1, 1, 16, 2, 5, 0, 0, 0,   0,  3}, // R3 event offered
    '{0, 0, 16, 0, 0, 0, 0,  0, 0, 0, 0, 0, 0,   0,  3}, // R3 low event ignored
    '{1, 0, 17, 4, 3, 0, 0,  0, 0, 0, 1, 1, 0,   0,  9}, // R9 server out of range
    '{1, 0, 24, 1, 3, 0, 0,  0, 0, 0, 1, 1, 0,   0,  1}, // R1 source above range
    '{1, 3, 15, 0, 0, 0, 0,  0, 0, 0, 1, 1, 0,   0,  1}, // R1 source below range
    '{0, 0, 24, 0, 0, 1, 0,  0, 0, 0, 0, 0, 0,   0,  1}, // R1 event out of range
    '{0, 0, 17, 0, 0, 1, 0,  0, 0, 0, 0, 0, 0,   0,  4}, // R4 masked event
    '{1, 2, 17, 0, 0, 0, 0,  0, 0, 0, 1, 0, 0, 255, 10}, // R10 on restores 0xFF
    '{1, 0, 17, 3, 9, 0, 1, 17, 3, 9, 1, 0, 3,   9,  4}, // R4 pending released once
    '{0, 0, 17, 0, 0, 1, 1, 17, 3, 9, 0, 0, 0,   0,  3}, // R3
    '{1, 0, 20, 1, 7, 0, 0,  0, 0, 0, 1, 0, 1,   7,  5}, // R5 level not asserted
    '{0, 0, 20, 0, 0, 1, 1, 20, 1, 7, 0, 0, 0,   0,  5}, // R5 level offered
    '{0, 0, 20, 0, 0, 1, 0,  0, 0, 0, 0, 0, 0,   0,  5}, // R5 sent blocks repeat
    '{3, 0, 20, 0, 0, 0, 0,  0, 0, 0, 0, 0, 0,   0,  7}, // R7 eoi silent
    '{0, 0, 20, 0, 0, 1, 1, 20, 1, 7, 0, 0, 0,   0,  7}, // R7 eoi cleared sent
    '{2, 0, 20, 0, 0, 0, 0,  0, 0, 0, 0, 0, 0,   0,  6}, // R6 reject silent
    '{1, 1, 20, 0, 0, 0, 0,  0, 0, 0, 1, 0, 1, 255, 10}, // R10 off
    '{1, 2, 20, 0, 0, 0, 1, 20, 1, 7, 1, 0, 1,   7, 10}, // R10 R6 on re-offers
    '{0, 0, 20, 0, 0, 0, 0,  0, 0, 0, 0, 0, 0,   0,  5}, // R5 deassert
    '{3, 0, 20, 0, 0, 0, 0,  0, 0, 0, 0, 0, 0,   0,  7}, // R7
    '{0, 0, 20, 0, 0, 1, 1, 20, 1, 7, 0, 0, 0,   0,  7}  // R7
  };

  logic       clk, rst_n;
  logic       evt_valid, evt_level, cfg_valid, rej_valid, eoi_valid, resend;
  logic [9:0] evt_src, cfg_src, rej_src, eoi_src;
  logic [1:0] cfg_cmd;
  logic [7:0] cfg_server, cfg_prio;
  logic       cfg_done, cfg_err, offer_valid;
  logic [1:0] cfg_rd_server, offer_server;
  logic [7:0] cfg_rd_prio, offer_prio;
  logic [9:0] offer_src;

  int checks = 0, errs = 0;
  int got_n;
  int got_src [16];
  int got_prio [16];

  irq_src_ctl u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_src(evt_src),
    .evt_level(evt_level), .cfg_valid(cfg_valid), .cfg_cmd(cfg_cmd),
    .cfg_src(cfg_src), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
    .cfg_done(cfg_done), .cfg_err(cfg_err), .cfg_rd_server(cfg_rd_server),
    .cfg_rd_prio(cfg_rd_prio), .rej_valid(rej_valid), .rej_src(rej_src),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend(resend),
    .offer_valid(offer_valid), .offer_src(offer_src),
    .offer_server(offer_server), .offer_prio(offer_prio)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input logic ok, input int req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL R%0d %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    evt_valid = 0; evt_src = 0; evt_level = 0;
    cfg_valid = 0; cfg_cmd = 0; cfg_src = 0; cfg_server = 0; cfg_prio = 0;
    rej_valid = 0; rej_src = 0; eoi_valid = 0; eoi_src = 0; resend = 0;
  endtask

  task automatic drive(input vec_t v);
    case (int'(v.kind))
      K_EVT: begin evt_valid = 1; evt_src = v.src; evt_level = v.lvl; end
      K_CFG: begin
        cfg_valid = 1; cfg_cmd = v.cmd; cfg_src = v.src;
        cfg_server = v.srv; cfg_prio = v.prio;
      end
      K_REJ: begin rej_valid = 1; rej_src = v.src; end
      default: begin eoi_valid = 1; eoi_src = v.src; end
    endcase
  endtask

  // sample offers for n cycles at the falling edge
  task automatic collect(input int n, input logic hold_read);
    got_n = 0;
    for (int c = 0; c < n; c++) begin
      if (hold_read) begin cfg_valid = 1; cfg_cmd = 2'd3; cfg_src = 10'd16; end
      @(negedge clk);
      if (offer_valid && got_n < 16) begin
        got_src[got_n]  = int'(offer_src);
        got_prio[got_n] = int'(offer_prio);
        got_n++;
      end
    end
    idle();
  endtask

  task automatic pulse_src(input int kind, input int src);
    @(negedge clk);
    if (kind == K_REJ) begin rej_valid = 1; rej_src = 10'(src); end
    else begin resend = 1; end
    @(negedge clk);
    idle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, 0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2: quiet after reset
    chk(offer_valid == 0, 2, "offer_valid after reset", offer_valid, 0);
    chk(cfg_done == 0, 2, "cfg_done after reset", cfg_done, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      @(negedge clk);
      drive(v);
      @(negedge clk);
      chk(offer_valid == v.x_off, v.req, $sformatf("row %0d offer_valid", i),
          offer_valid, v.x_off);
      if (v.x_off && offer_valid) begin
        chk(offer_src == v.x_src, v.req, "offer_src", offer_src, v.x_src);
        chk(offer_server == v.x_srv, v.req, "offer_server", offer_server, v.x_srv);
        chk(offer_prio == v.x_prio, v.req, "offer_prio", offer_prio, v.x_prio);
      end
      // R13 completion strobe one cycle after the command
      chk(cfg_done == v.x_done, 13, $sformatf("row %0d cfg_done", i), cfg_done, v.x_done);
      if (v.x_done && cfg_done) begin
        chk(cfg_err == v.x_err, v.req, "cfg_err", cfg_err, v.x_err);
        if (!v.x_err) begin
          chk(cfg_rd_server == v.x_rsrv, 11, "cfg_rd_server", cfg_rd_server, v.x_rsrv);
          chk(cfg_rd_prio == v.x_rprio, 11, "cfg_rd_prio", cfg_rd_prio, v.x_rprio);
        end
      end
      idle();
    end

    // R12: event outranks a command in the same cycle
    @(negedge clk);
    evt_valid = 1; evt_src = 10'd16; evt_level = 1;
    cfg_valid = 1; cfg_cmd = 2'd3; cfg_src = 10'd17;
    @(negedge clk);
    chk(offer_valid && offer_src == 10'd16, 12, "event wins", offer_src, 16);
    chk(cfg_done == 0, 12, "dropped command done", cfg_done, 0);
    idle();

    // R8: scan replays rejected message 16 and unsent level 20, in order
    pulse_src(K_REJ, 16);
    pulse_src(K_REJ, 20);
    pulse_src(-1, 0);
    collect(12, 1'b0);
    chk(got_n == 2, 8, "scan offer count", got_n, 2);
    if (got_n == 2) begin
      chk(got_src[0] == 16 && got_prio[0] == 5, 8, "first scan offer", got_src[0], 16);
      chk(got_src[1] == 20 && got_prio[1] == 7, 8, "second scan offer", got_src[1], 20);
    end

    // R8: nothing left to replay
    pulse_src(-1, 0);
    collect(12, 1'b0);
    chk(got_n == 0, 8, "idle scan offers", got_n, 0);

    // R8: scan held while commands keep arriving, resumes afterwards
    pulse_src(K_REJ, 16);
    pulse_src(-1, 0);
    collect(12, 1'b1);
    chk(got_n == 0, 8, "offers while stalled", got_n, 0);
    collect(12, 1'b0);
    chk(got_n == 1, 8, "offers after stall", got_n, 1);
    if (got_n == 1) chk(got_src[0] == 16, 8, "resumed offer src", got_src[0], 16);

    // R2: reset again clears routing
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    cfg_valid = 1; cfg_cmd = 2'd3; cfg_src = 10'd20;
    @(negedge clk);
    chk(cfg_done && cfg_rd_prio == 8'hFF, 2, "prio after reset", cfg_rd_prio, 255);
    chk(cfg_rd_server == 0, 2, "server after reset", cfg_rd_server, 0);
    idle();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule